// File: doc/BRIEF.md
# Data Space Address Decoder

This block sits between a CPU load/store port and the data-side memories. It decodes each 16-bit data-space address into one of four fixed internal regions: the working register file, the standard I/O registers, the extended I/O registers and internal SRAM. It returns the read byte of whichever region is selected. An internal access completes in the cycle it is presented, and the CPU never stalls for one.

Addresses above internal SRAM belong to an optional external SRAM. While the external-memory enable input is set, such an access runs a registered bus cycle on active-low read and write strobes, with a programmable 0 to 3 wait states. The CPU is held through `cpu_ready` until the access completes. While the enable is clear, the same addresses are treated as unmapped. The request must stay unchanged while `cpu_ready` is low.

Top module: `dspace_decoder`

## Requirements
- R1: An access (`cpu_rd` or `cpu_wr` high) to 0x0000–0x001F raises `sel_regf`, and a read returns `regf_rdata` on `cpu_rdata`.
- R2: An access to 0x0020–0x005F raises `sel_io`, and a read returns `io_rdata`.
- R3: An access to 0x0060–0x00FF raises `sel_xio`, and a read returns `xio_rdata`.
- R4: An access to 0x0100–0x10FF raises `sel_sram`, and a read returns `sram_rdata`.
- R5: At most one region select is high at a time, and none is high when there is no request.
- R6: During any internal-region access both external strobes stay high and `cpu_ready` stays high, so the access completes in its first cycle.
- R7: With the enable set, an access at or above 0x1100 drops `cpu_ready` in the request cycle. The strobe is then active for W+1 cycles, where W is `xmem_wait` (0–3). `cpu_ready` is high only in the last of those cycles, so the access takes W+1 more cycles than an internal one.
- R8: An external read returns `ext_rdata` on `cpu_rdata` in its completion cycle. An external write presents the request's byte on `ext_wdata` while `ext_wr_n` is low.
- R9: `ext_addr` and `ext_wdata` hold the request's address and data and stay stable for the whole time a strobe is active.
- R10: With the enable clear, an access at or above 0x1100 raises `unmapped`, asserts no strobe, returns 0x00 and completes with `cpu_ready` high. A write made this way does not change external memory.
- R11: After reset both strobes are high, `cpu_ready` is high and `unmapped` is low. The two strobes are never low together, and a read takes precedence if both `cpu_rd` and `cpu_wr` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | Data-space address |
| cpu_rd | input | 1 | Read request |
| cpu_wr | input | 1 | Write request |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte |
| cpu_ready | output | 1 | High when the access completes this cycle |
| xmem_en | input | 1 | External memory enable |
| xmem_wait | input | 2 | External wait states (0–3) |
| sel_regf | output | 1 | Register file select |
| sel_io | output | 1 | Standard I/O select |
| sel_xio | output | 1 | Extended I/O select |
| sel_sram | output | 1 | Internal SRAM select |
| regf_rdata | input | 8 | Register file read byte |
| io_rdata | input | 8 | Standard I/O read byte |
| xio_rdata | input | 8 | Extended I/O read byte |
| sram_rdata | input | 8 | Internal SRAM read byte |
| unmapped | output | 1 | Access above internal SRAM while external memory is disabled |
| ext_addr | output | 16 | External address (registered) |
| ext_wdata | output | 8 | External write byte (registered) |
| ext_rdata | input | 8 | External read byte |
| ext_rd_n | output | 1 | External read strobe, active low |
| ext_wr_n | output | 1 | External write strobe, active low |

## Verification
A wrong busy flag or wait counter shows up at the ports within the same external access. The strobe window is too short or too long, or `cpu_ready` rises in the wrong cycle. The reference model compares both on every clock, so the fault is reported in the first cycle it occurs. A bad address latch or data path shows up in the completion cycle of a read, or in the next read of the same location after a write. That read returns the wrong byte. A bad region boundary shows up as the wrong select at the edge addresses on either side.

// File: rtl/dspace_decoder.sv
module dspace_decoder #(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int REGF_N = 32,
  parameter int IO_N   = 64,
  parameter int XIO_N  = 160,
  parameter int SRAM_N = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_ready,
  input  logic          xmem_en,
  input  logic [1:0]    xmem_wait,
  output logic          sel_regf,
  output logic          sel_io,
  output logic          sel_xio,
  output logic          sel_sram,
  input  logic [DW-1:0] regf_rdata,
  input  logic [DW-1:0] io_rdata,
  input  logic [DW-1:0] xio_rdata,
  input  logic [DW-1:0] sram_rdata,
  output logic          unmapped,
  output logic [AW-1:0] ext_addr,
  output logic [DW-1:0] ext_wdata,
  input  logic [DW-1:0] ext_rdata,
  output logic          ext_rd_n,
  output logic          ext_wr_n
);
  localparam logic [AW-1:0] IO_B   = AW'(REGF_N);
  localparam logic [AW-1:0] XIO_B  = AW'(REGF_N + IO_N);
  localparam logic [AW-1:0] SRAM_B = AW'(REGF_N + IO_N + XIO_N);
  localparam logic [AW-1:0] EXT_B  = AW'(REGF_N + IO_N + XIO_N + SRAM_N);

  logic       busy;
  logic [1:0] cnt;
  logic       req, hit_ext, start, last;

  assign req     = cpu_rd | cpu_wr;
  assign hit_ext = req && (cpu_addr >= EXT_B);
  assign start   = !busy && hit_ext && xmem_en;
  assign last    = busy && (cnt == 2'd0);

  assign sel_regf = req && (cpu_addr < IO_B);
  assign sel_io   = req && (cpu_addr >= IO_B)   && (cpu_addr < XIO_B);
  assign sel_xio  = req && (cpu_addr >= XIO_B)  && (cpu_addr < SRAM_B);
  assign sel_sram = req && (cpu_addr >= SRAM_B) && (cpu_addr < EXT_B);
  assign unmapped = !busy && hit_ext && !xmem_en;

  assign cpu_ready = busy ? last : !start;

  always_comb begin
    cpu_rdata = '0;
    if (busy) begin
      if (last && !ext_rd_n) cpu_rdata = ext_rdata;
    end else if (sel_regf) cpu_rdata = regf_rdata;
    else if (sel_io)       cpu_rdata = io_rdata;
    else if (sel_xio)      cpu_rdata = xio_rdata;
    else if (sel_sram)     cpu_rdata = sram_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      ext_rd_n  <= 1'b1;
      ext_wr_n  <= 1'b1;
      ext_addr  <= '0;
      ext_wdata <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      cnt       <= xmem_wait;
      ext_rd_n  <= !cpu_rd;
      ext_wr_n  <= !(cpu_wr && !cpu_rd);
      ext_addr  <= cpu_addr;
      ext_wdata <= cpu_wdata;
    end else if (last) begin
      busy     <= 1'b0;
      ext_rd_n <= 1'b1;
      ext_wr_n <= 1'b1;
    end else if (busy) begin
      cnt <= cnt - 2'd1;
    end
  end
endmodule

module dspace_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_ready,
  input logic [7:0]  cpu_rdata,
  input logic [1:0]  xmem_wait,
  input logic        sel_regf,
  input logic        sel_io,
  input logic        sel_xio,
  input logic        sel_sram,
  input logic        unmapped,
  input logic [15:0] ext_addr,
  input logic [7:0]  ext_wdata,
  input logic        ext_rd_n,
  input logic        ext_wr_n
);
  logic       act;
  logic [2:0] lowcnt;
  logic [1:0] wq;
  assign act = !ext_rd_n || !ext_wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowcnt <= '0;
      wq     <= '0;
    end else if (!act) begin
      lowcnt <= '0;
      wq     <= xmem_wait;
    end else begin
      lowcnt <= lowcnt + 3'd1;
    end
  end

  // R5
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_regf, sel_io, sel_xio, sel_sram}));
  // R6
  int_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_regf || sel_io || sel_xio || sel_sram) |-> (ext_rd_n && ext_wr_n && cpu_ready));
  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && $past(act)) |-> ($stable(ext_addr) && $stable(ext_wdata)));
  // R10
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (cpu_ready && ext_rd_n && ext_wr_n && cpu_rdata == 8'h00));
  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n));
  // R7
  stall_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act) |-> $past(!cpu_ready));
  // R7
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act) |-> (lowcnt == ({1'b0, wq} + 3'd1)));
endmodule

bind dspace_decoder dspace_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
  .xmem_wait(xmem_wait), .sel_regf(sel_regf), .sel_io(sel_io), .sel_xio(sel_xio),
  .sel_sram(sel_sram), .unmapped(unmapped), .ext_addr(ext_addr),
  .ext_wdata(ext_wdata), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
);

// File: tb/tb_dspace_decoder.sv
module tb_dspace_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_ready;
  logic        xmem_en = 1'b0;
  logic [1:0]  xmem_wait = '0;
  logic        sel_regf, sel_io, sel_xio, sel_sram, unmapped;
  logic [7:0]  regf_rdata, io_rdata, xio_rdata, sram_rdata, ext_rdata, ext_wdata;
  logic [15:0] ext_addr;
  logic        ext_rd_n, ext_wr_n;

  int checks = 0, errors = 0;
  logic [7:0] bus_mem   [0:65535];
  logic [7:0] model_mem [0:65535];

  always #2 clk = ~clk;

  assign regf_rdata = 8'h10 ^ cpu_addr[7:0];
  assign io_rdata   = 8'h20 ^ cpu_addr[7:0];
  assign xio_rdata  = 8'h40 ^ cpu_addr[7:0];
  assign sram_rdata = 8'h80 ^ cpu_addr[7:0] ^ cpu_addr[15:8];
  assign ext_rdata  = ext_rd_n ? 8'hEE : bus_mem[ext_addr];

  always @(posedge clk) if (!ext_wr_n) bus_mem[ext_addr] <= ext_wdata;

  dspace_decoder dut (.*);

  task automatic chk(string r, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", r, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] region(logic [15:0] a);
    if (a <= 16'h001F) return 4'b0001;
    if (a <= 16'h005F) return 4'b0010;
    if (a <= 16'h00FF) return 4'b0100;
    if (a <= 16'h10FF) return 4'b1000;
    return 4'b0000;
  endfunction

  function automatic logic [7:0] int_data(logic [15:0] a);
    case (region(a))
      4'b0001: return 8'h10 ^ a[7:0];
      4'b0010: return 8'h20 ^ a[7:0];
      4'b0100: return 8'h40 ^ a[7:0];
      4'b1000: return 8'h80 ^ a[7:0] ^ a[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic idle();
    @(negedge clk);
    cpu_rd = 0; cpu_wr = 0;
    #1;
    chk("R5 idle selects", {sel_regf, sel_io, sel_xio, sel_sram}, 0);
    chk("R11 idle strobes/ready/unmapped", {ext_rd_n, ext_wr_n, cpu_ready, unmapped}, 4'b1110);
    @(posedge clk);
  endtask

  task automatic access(bit rd, bit wr, logic [15:0] a, logic [7:0] d, logic [1:0] w, bit en);
    bit ext = (a >= 16'h1100);
    bit isrd = rd;
    int rem = -1;
    int cyc = 0;
    bit done = 0;
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d; xmem_wait = w; xmem_en = en;
    while (!done) begin
      #1;
      chk("R1-R4 region select R1 R2 R3 R4 R5", {sel_sram, sel_xio, sel_io, sel_regf}, region(a));
      if (rem < 0) begin
        if (ext && en) begin
          chk("R7 ready low in request cycle", cpu_ready, 0);
          chk("R7 strobes idle in request cycle", {ext_rd_n, ext_wr_n}, 2'b11);
        end else begin
          done = 1;
          chk("R6 R10 ready and no strobe", {cpu_ready, ext_rd_n, ext_wr_n}, 3'b111);
          chk("R10 unmapped flag", unmapped, ext);
          if (isrd) chk(ext ? "R10 unmapped read data" : "R1 R2 R3 R4 read data",
                        cpu_rdata, int_data(a));
        end
      end else begin
        chk("R7 R11 strobe levels", {ext_rd_n, ext_wr_n}, isrd ? 2'b01 : 2'b10);
        chk("R9 ext_addr held", ext_addr, a);
        if (!isrd) chk("R8 R9 ext_wdata", ext_wdata, d);
        chk("R7 ready only in last strobe cycle", cpu_ready, rem == 0);
        if (rem == 0) begin
          done = 1;
          if (isrd) chk("R8 external read data", cpu_rdata, model_mem[a]);
          else model_mem[a] = d;
        end
      end
      if (done) chk("R7 access length", 16'(cyc), (ext && en) ? 16'(w + 1) : 16'd0);
      @(posedge clk);
      if (rem < 0 && ext && en) rem = w;
      else if (rem >= 0) rem--;
      cyc++;
    end
    idle();
  endtask

  initial begin
    for (int i = 0; i < 65536; i++) begin bus_mem[i] = 8'h00; model_mem[i] = 8'h00; end
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #11;
    chk("R11 reset strobes/ready/unmapped", {ext_rd_n, ext_wr_n, cpu_ready, unmapped}, 4'b1110);
    @(negedge clk); rst_n = 1;
    idle();
    foreach (int_list[i]) ;
    // R1 R2 R3 R4 boundaries
    access(1, 0, 16'h0000, 0, 0, 1);
    access(1, 0, 16'h001F, 0, 0, 1);
    access(1, 0, 16'h0020, 0, 0, 1);
    access(1, 0, 16'h005F, 0, 0, 1);
    access(1, 0, 16'h0060, 0, 0, 1);
    access(1, 0, 16'h00FF, 0, 0, 1);
    access(1, 0, 16'h0100, 0, 0, 1);
    access(0, 1, 16'h10FF, 8'h33, 0, 1);
    access(1, 0, 16'h10FF, 0, 0, 1);
    // R7 R8 R9 every wait setting
    for (int w = 0; w < 4; w++) begin
      access(0, 1, 16'h1100 + 16'(w), 8'hA0 + 8'(w), 2'(w), 1);
      access(1, 0, 16'h1100 + 16'(w), 0, 2'(3 - w), 1);
    end
    access(0, 1, 16'hFFFF, 8'h5C, 2, 1);
    access(1, 0, 16'hFFFF, 0, 1, 1);
    // R11 read precedence
    access(1, 1, 16'h2345, 8'h77, 1, 1);
    // R10 unmapped, write must not reach memory
    access(0, 1, 16'h1101, 8'hFF, 3, 0);
    access(1, 0, 16'h1101, 0, 0, 0);
    access(1, 0, 16'h1101, 0, 0, 1);
    access(0, 1, 16'h0040, 8'h12, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int int_list[1] = '{0};
endmodule